// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the digital control core of a four-channel, simultaneous-sampling data converter. A short convert-start pulse launches a sequence that runs one conversion per channel for one to four channels, always beginning with the lowest channel and counting upward. Every conversion occupies a fixed window of clock cycles. At the end of each window the converter's data word is stored in a small result memory, one entry per channel. When the final channel of the sequence has been stored, an active-low interrupt is raised.

Software or a host state machine then pulses a read strobe once per result. Each strobe returns the next stored word, in channel order, and the first strobe also withdraws the interrupt. A 4-bit control word selects the number of channels and which of the two input banks feeds the sample-and-hold stage. The same word can put the block into a low-power state. The channel count and bank stay in force across start pulses until they are written again. The analog side is represented by a select output (channel index and bank) plus a data input that is sampled on the last cycle of each conversion window. Results pass through untouched and are interpreted as two's complement.

Top module: `adc_seq_core`

## Requirements
- R1: After reset, int_n is high, cnv_active and sleep are low, and the stored mode is one channel from bank A (bank value 0).
- R2: A cfg_wr pulse stores cfg_word with bits [1:0] = channel count minus one, bit 2 = bank (0 = A, 1 = B) and bit 3 = power-down. The stored count and bank apply to every later start until the next write.
- R3: An accepted start raises cnv_active in the following cycle. It stays high for exactly count × CONV_CYCLES cycles (48 by default). During that time cnv_chan steps 0, 1, … up to count−1, one step per window, and cnv_bank shows the bank in use.
- R4: On the last cycle of each channel's window, cnv_data is written into the result entry whose index equals that channel.
- R5: int_n goes low in the cycle after the last channel's result is stored. It stays low until an accepted start or a read strobe.
- R6: A read strobe loads rd_data on the next clock with the entry at the read pointer and then advances the pointer, wrapping from 3 to 0. An accepted start returns the pointer to entry 0. rd_data holds its value when no strobe is given.
- R7: int_n is high in the cycle after an accepted start or after a read strobe.
- R8: A start pulse is ignored while a sequence is running or while the block is powered down.
- R9: A write with bit 3 set raises sleep on the next cycle and abandons any running sequence without raising the interrupt. A write with bit 3 clear lowers sleep and applies the new count and bank.
- R10: A control write made during a running sequence leaves that sequence's count and bank unchanged and takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe that stores cfg_word |
| cfg_word | input | 4 | Control word: [1:0] count−1, [2] bank, [3] power-down |
| start | input | 1 | One-cycle convert-start pulse |
| rd | input | 1 | One-cycle read strobe |
| cnv_data | input | DATA_W | Converter result for the selected channel |
| cnv_active | output | 1 | A conversion sequence is running |
| cnv_chan | output | 2 | Channel index being converted |
| cnv_bank | output | 1 | Input bank of the running sequence |
| sleep | output | 1 | Power-down state |
| int_n | output | 1 | Active-low end-of-sequence interrupt |
| rd_data | output | DATA_W | Result word returned by the last read strobe |

## Verification
The bench drives start pulses in the middle of a running sequence. A design that restarted would stretch the active time or return channel 0 twice. It writes a new count and bank mid-sequence, which a design that read the live mode would expose through a shortened sequence and bank-A data in bank-B entries. It also reads past the last entry to check that the pointer wraps, and it checks that a start clears the interrupt without any read. Power-down is entered both while idle and mid-sequence. A design that let a start through while asleep, or that flagged an aborted sequence as complete, would show cnv_active or a low int_n that the reference model does not predict.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // Channel count is fixed by the 2-bit count field of the control word.
  localparam int SEQ_NCH  = 4;
  localparam int SEQ_CH_W = $clog2(SEQ_NCH);

  typedef enum logic {ST_IDLE, ST_CONV} seq_state_e;

  typedef struct packed {
    logic                pwr_down;
    logic                bank;
    logic [SEQ_CH_W-1:0] cnt_m1;
  } ctl_word_t;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  ctl_word_t           cfg_word,
  output logic [SEQ_CH_W-1:0] mode_cnt,
  output logic                mode_bank,
  output logic                sleep
);
  logic [SEQ_CH_W-1:0] cnt_q, cnt_d;
  logic                bank_q, bank_d, sleep_q, sleep_d;

  always_comb begin
    cnt_d   = cnt_q;
    bank_d  = bank_q;
    sleep_d = sleep_q;
    if (cfg_wr) begin
      cnt_d   = cfg_word.cnt_m1;
      bank_d  = cfg_word.bank;
      sleep_d = cfg_word.pwr_down;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bank_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      bank_q  <= bank_d;
      sleep_q <= sleep_d;
    end
  end

  assign mode_cnt  = cnt_q;
  assign mode_bank = bank_q;
  assign sleep     = sleep_q;

  // R2: mode persists without a write
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(cnt_q) && $stable(bank_q) && $stable(sleep_q)));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 48   // at least 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rd,
  input  logic                sleep,
  input  logic                abort,
  input  logic [SEQ_CH_W-1:0] mode_cnt,
  input  logic                mode_bank,
  output logic                active,
  output logic [SEQ_CH_W-1:0] chan,
  output logic                bank,
  output logic                cap_we,
  output logic                start_ok,
  output logic                int_n
);
  localparam int              TMR_W    = $clog2(CONV_CYCLES);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CONV_CYCLES - 1);

  seq_state_e          state_q, state_d;
  logic [TMR_W-1:0]    tmr_q, tmr_d;
  logic [SEQ_CH_W-1:0] chan_q, chan_d, last_q, last_d;
  logic                bank_q, bank_d, int_n_q, int_n_d;
  logic                at_end, seq_done;

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    chan_d   = chan_q;
    last_d   = last_q;
    bank_d   = bank_q;
    int_n_d  = int_n_q;
    at_end   = (state_q == ST_CONV) && (tmr_q == TMR_LAST);
    start_ok = start && (state_q == ST_IDLE) && !sleep && !abort;
    cap_we   = at_end && !abort;
    seq_done = cap_we && (chan_q == last_q);
    if (start_ok) begin
      state_d = ST_CONV;
      tmr_d   = '0;
      chan_d  = '0;
      last_d  = mode_cnt;
      bank_d  = mode_bank;
    end else if (state_q == ST_CONV) begin
      if (abort) begin
        state_d = ST_IDLE;
      end else if (at_end) begin
        tmr_d = '0;
        if (seq_done) state_d = ST_IDLE;
        else          chan_d  = chan_q + 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
    if (start_ok || rd) int_n_d = 1'b1;
    if (seq_done)       int_n_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      chan_q  <= '0;
      last_q  <= '0;
      bank_q  <= 1'b0;
      int_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      chan_q  <= chan_d;
      last_q  <= last_d;
      bank_q  <= bank_d;
      int_n_q <= int_n_d;
    end
  end

  assign active = (state_q == ST_CONV);
  assign chan   = chan_q;
  assign bank   = bank_q;
  assign int_n  = int_n_q;

  // R3: timer and channel stay in range while converting
  assert_tmr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (tmr_q <= TMR_LAST));
  assert_chan_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (chan_q <= last_q));
  // R8: a start during a window does not restart the timer
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && !abort && !at_end) |=> (tmr_q == $past(tmr_q) + 1'b1));
  // R8: powered down and idle stays idle
  assert_sleep_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && sleep) |=> !active);
  // R5: completion raises the interrupt and ends the run
  assert_done_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!int_n && !active));
  // R7: accepted start clears interrupt and begins at channel 0
  assert_start_clears_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (int_n && active && chan_q == '0));
  // R9: abort ends the run without interrupt
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && abort) |=> (!active && int_n));
endmodule

// File: rtl/adc_seq_ram.sv
module adc_seq_ram #(
  parameter int DATA_W = 14,
  parameter int N_ENT  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(N_ENT)-1:0] widx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     rd,
  input  logic                     ptr_clr,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int                AW      = $clog2(N_ENT);
  localparam logic [AW-1:0]     PTR_TOP = AW'(N_ENT - 1);

  logic [DATA_W-1:0] mem [N_ENT];
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (widx == AW'(e));
    always_ff @(posedge clk) begin
      if (ent_en) mem[e] <= wdata;
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    rdat_d = rdat_q;
    if (rd) begin
      rdat_d = mem[ptr_q];
      ptr_d  = (ptr_q == PTR_TOP) ? '0 : ptr_q + 1'b1;
    end
    if (ptr_clr) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      rdat_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_data = rdat_q;

  // R6: output holds without a strobe; a start rewinds the pointer
  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rd_data));
  assert_ptr_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (ptr_q == '0));
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [3:0]          cfg_word,
  input  logic                start,
  input  logic                rd,
  input  logic [DATA_W-1:0]   cnv_data,
  output logic                cnv_active,
  output logic [SEQ_CH_W-1:0] cnv_chan,
  output logic                cnv_bank,
  output logic                sleep,
  output logic                int_n,
  output logic [DATA_W-1:0]   rd_data
);
  logic [1:0]          rst_pipe_q;
  logic                rst_int_n;
  ctl_word_t           word;
  logic [SEQ_CH_W-1:0] mode_cnt;
  logic                mode_bank, abort, cap_we, start_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign word  = ctl_word_t'(cfg_word);
  assign abort = cfg_wr && word.pwr_down;

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_word(word),
    .mode_cnt(mode_cnt), .mode_bank(mode_bank), .sleep(sleep)
  );

  adc_seq_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start(start), .rd(rd), .sleep(sleep),
    .abort(abort), .mode_cnt(mode_cnt), .mode_bank(mode_bank),
    .active(cnv_active), .chan(cnv_chan), .bank(cnv_bank),
    .cap_we(cap_we), .start_ok(start_ok), .int_n(int_n)
  );

  adc_seq_ram #(.DATA_W(DATA_W), .N_ENT(SEQ_NCH)) u_ram (
    .clk(clk), .rst_n(rst_int_n), .we(cap_we), .widx(cnv_chan),
    .wdata(cnv_data), .rd(rd), .ptr_clr(start_ok), .rd_data(rd_data)
  );

  // R1: interrupt inactive straight out of reset
  assert_reset_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> int_n);
endmodule

// File: tb/test_adc_seq_core.sv
module test_adc_seq_core;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_word = 4'b0000;
  logic        start = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  salt = 8'h00;
  logic [13:0] cnv_data;
  logic        cnv_active, cnv_bank, sleep, int_n;
  logic [1:0]  cnv_chan;
  logic [13:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] conv_word(logic [7:0] s, logic b, logic [1:0] c);
    return {s, b, 3'b000, c};
  endfunction

  assign cnv_data = conv_word(salt, cnv_bank, cnv_chan);

  adc_seq_core i_adc_seq_core (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .start(start), .rd(rd), .cnv_data(cnv_data), .cnv_active(cnv_active),
    .cnv_chan(cnv_chan), .cnv_bank(cnv_bank), .sleep(sleep), .int_n(int_n),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_rs = 0;
  bit m_act = 0, m_bankrun = 0, m_bank = 0, m_sleep = 0, m_int = 1;
  int m_tmr = 0, m_ch = 0, m_last = 0, m_cnt = 0, m_ptr = 0;
  logic [13:0] m_rd = '0;
  logic [13:0] m_ram [4];

  always @(posedge clk) begin
    automatic bit old_act = m_act, old_sleep = m_sleep, old_bank = m_bank;
    automatic int old_cnt = m_cnt;
    automatic bit abort, go, done;
    if (!rst_n || m_rs < 2) begin
      m_rs = rst_n ? m_rs + 1 : 0;
      m_act = 0; m_bankrun = 0; m_bank = 0; m_sleep = 0; m_int = 1;
      m_tmr = 0; m_ch = 0; m_last = 0; m_cnt = 0; m_ptr = 0; m_rd = '0;
    end else begin
      abort = cfg_wr && cfg_word[3];
      go = start && !old_act && !old_sleep && !abort;
      done = 0;
      if (cfg_wr) begin
        m_cnt = cfg_word[1:0]; m_bank = cfg_word[2]; m_sleep = cfg_word[3];
      end
      if (rd) begin
        m_rd = m_ram[m_ptr];
        m_ptr = (m_ptr + 1) % 4;
        m_int = 1;
      end
      if (go) begin
        m_act = 1; m_tmr = 0; m_ch = 0; m_last = old_cnt; m_bankrun = old_bank;
        m_int = 1; m_ptr = 0;
      end else if (old_act) begin
        if (abort) m_act = 0;
        else if (m_tmr == CONV - 1) begin
          m_ram[m_ch] = cnv_data;
          m_tmr = 0;
          if (m_ch == m_last) begin m_act = 0; done = 1; end
          else m_ch++;
        end else m_tmr++;
      end
      if (done) m_int = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 cnv_active", cnv_active, m_act);
      chk("R3 cnv_chan", cnv_chan, m_ch);
      chk("R2 cnv_bank", cnv_bank, m_bankrun);
      chk("R9 sleep", sleep, m_sleep);
      chk("R5 int_n", int_n, m_int);
      chk("R6 rd_data", rd_data, m_rd);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic write_cfg(input logic [3:0] w);
    @(negedge clk) cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic read_one(input string tag, input logic [13:0] exp);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    chk(tag, rd_data, exp);
    chk("R7 int_n high after read", int_n, 1'b1);
  endtask

  task automatic run_seq(input int mid_at, input bit mid_start, input bit mid_wr,
                         input logic [3:0] mid_word, output int n);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (cnv_active && n < 2000) begin
      if (n == mid_at) begin start = mid_start; cfg_wr = mid_wr; cfg_word = mid_word; end
      else begin start = 1'b0; cfg_wr = 1'b0; end
      n++;
      @(negedge clk);
    end
    start = 1'b0; cfg_wr = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    // R1 reset state
    chk("R1 int_n", int_n, 1'b1);
    chk("R1 cnv_active", cnv_active, 1'b0);
    chk("R1 sleep", sleep, 1'b0);

    // default mode: one channel from bank A, negative code
    salt = 8'hF3;
    run_seq(-1, 0, 0, 4'h0, n);
    chk("R1 default length one window", n, CONV);
    chk("R5 int_n low at end", int_n, 1'b0);
    read_one("R4 default entry 0", conv_word(8'hF3, 1'b0, 2'd0));

    // four channels, bank B; mid-run start and mid-run rewrite
    write_cfg(4'b0111);
    salt = 8'h2A;
    run_seq(10, 1, 1, 4'b0001, n);
    chk("R8 busy start ignored, full length", n, 4*CONV);
    for (int c = 0; c < 4; c++)
      read_one("R10 entries from bank B", conv_word(8'h2A, 1'b1, c[1:0]));
    read_one("R6 pointer wraps to entry 0", conv_word(8'h2A, 1'b1, 2'd0));

    // new mode (two channels, bank A) applies now; start clears int
    salt = 8'h81;
    run_seq(-1, 0, 0, 4'h0, n);
    chk("R10 two-channel length", n, 2*CONV);
    chk("R5 int_n low", int_n, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R7 start clears int_n", int_n, 1'b1);
    chk("R6 restart active", cnv_active, 1'b1);
    while (cnv_active) @(negedge clk);
    read_one("R6 rewound pointer entry 0", conv_word(8'h81, 1'b0, 2'd0));
    read_one("R4 entry 1", conv_word(8'h81, 1'b0, 2'd1));

    // power-down while idle: start ignored
    write_cfg(4'b1000);
    chk("R9 sleep set", sleep, 1'b1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 start ignored when asleep", cnv_active, 1'b0);

    // wake with three channels bank B
    write_cfg(4'b0110);
    chk("R9 sleep cleared", sleep, 1'b0);
    salt = 8'h5C;
    run_seq(-1, 0, 0, 4'h0, n);
    chk("R2 three-channel length", n, 3*CONV);
    read_one("R4 entry 0 bank B", conv_word(8'h5C, 1'b1, 2'd0));

    // power-down in mid-sequence aborts without interrupt
    run_seq(70, 0, 1, 4'b1011, n);
    chk("R9 abort length", n, 71);
    chk("R9 no interrupt on abort", int_n, 1'b1);
    chk("R9 asleep after abort", sleep, 1'b1);

    // wake into four channels bank A and finish
    write_cfg(4'b0011);
    salt = 8'hC0;
    run_seq(-1, 0, 0, 4'h0, n);
    chk("R3 four-channel length", n, 4*CONV);
    for (int c = 0; c < 4; c++)
      read_one("R4 entries bank A", conv_word(8'hC0, 1'b0, c[1:0]));

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule